// File: doc/BRIEF.md
# Two-Pitch Rectangle Transfer Address Generator

This block steps through a rectangular block copy between system memory and a frame buffer, one row at a time. Software programs a system-side base byte address, a row count, a row length in bytes, a frame-buffer base address (quadword aligned), a frame-buffer pitch in quadwords, a system pitch in bytes and a fill word. A start pulse then makes the block present one request per row on a valid/ready port. Each request carries a system address, a frame-buffer address, a byte length and a fill indication.

After every accepted row, the system address grows by its byte pitch. The frame-buffer address grows by its quadword pitch times eight. In fill mode, sampled with the start pulse, each request tells the data mover to write the fill word into the frame buffer instead of fetched data. Address translation and the data movement itself belong to other blocks.

Top module: `rect_xfer_agen`

## Requirements
- R1: After reset, busy, done and req_valid are low, and every configuration register reads back as zero.
- R2: Register select codes are: 0 system base (32 bits), 1 row count (bits 9:0), 2 row bytes (bits 11:0), 3 frame-buffer base (bits 19:3 kept, bits 2:0 forced zero), 4 frame-buffer pitch in quadwords (bits 9:0), 5 system pitch in bytes (bits 11:0), 6 fill word (32 bits). Bits outside a field read as zero.
- R3: A start pulse while idle with non-zero row count and row bytes raises busy in the next cycle. The first request then carries the system base, the frame-buffer base and a length equal to the row bytes.
- R4: While req_valid is high and req_ready is low, every request field holds its value.
- R5: After each accepted row that is not the last, the next system address equals the previous one plus the system pitch, modulo 2^32.
- R6: After each accepted row that is not the last, the next frame-buffer address equals the previous one plus eight times the quadword pitch, modulo 2^20.
- R7: Exactly row-count requests are issued, and req_last is high only on the final one.
- R8: done is high for exactly one cycle, in the cycle after the final request is accepted, and busy falls at that same point.
- R9: A start with a row count of zero or row bytes of zero raises done in the next cycle for one cycle. No request is issued and busy stays low.
- R10: When fill_en is high with start, every request has req_fill high and req_fill_data equal to the fill register. Otherwise req_fill is low and req_fill_data is zero.
- R11: Register writes and start pulses while busy have no effect on the current transfer or on register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_sel |
| start | input | 1 | Begin a transfer |
| fill_en | input | 1 | Fill mode, sampled with start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Row request valid |
| req_ready | input | 1 | Row request accepted |
| req_sys_addr | output | 32 | System-side byte address of the row |
| req_fb_addr | output | 20 | Frame-buffer byte address of the row |
| req_len | output | 12 | Row length in bytes |
| req_last | output | 1 | Final row of the transfer |
| req_fill | output | 1 | Write the fill word instead of fetched data |
| req_fill_data | output | 32 | Fill word, zero when not filling |

## Verification
The situation hardest to reach from the ports is a register write and a second start arriving while a transfer is stalled mid-way. Both have to land while busy is high and before any row has retired. The stimulus holds req_ready low, issues the write and the extra start during that stall, and then releases ready. The scoreboard confirms the rows still follow the original pitch, and a readback after done confirms the register kept its old value. Address wrap is forced with bases near the top of both address spaces and maximum pitches.

// File: rtl/rect_xfer_agen.sv
module rect_xfer_agen #(
  parameter int ROW_W = 10,
  parameter int LEN_W = 12,
  parameter int FB_AW = 20,
  parameter int FBP_W = 10,
  parameter int SPT_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        start,
  input  logic        fill_en,
  output logic        busy,
  output logic        done,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_sys_addr,
  output logic [FB_AW-1:0] req_fb_addr,
  output logic [LEN_W-1:0] req_len,
  output logic        req_last,
  output logic        req_fill,
  output logic [31:0] req_fill_data
);
  localparam int FB_STEP_PAD = FB_AW - FBP_W - 3;

  logic [31:0]      sysb_q;
  logic [ROW_W-1:0] rows_q;
  logic [LEN_W-1:0] width_q;
  logic [FB_AW-1:3] fbb_q;
  logic [FBP_W-1:0] fbp_q;
  logic [SPT_W-1:0] sysp_q;
  logic [31:0]      fillv_q;

  logic [31:0]      sys_ptr;
  logic [FB_AW-1:0] fb_ptr;
  logic [ROW_W-1:0] left_q;
  logic             mode_q;

  wire fire  = req_valid & req_ready;
  wire empty = (rows_q == '0) | (width_q == '0);
  wire go    = start & ~busy;
  wire [FB_AW-1:0] fb_step = {{FB_STEP_PAD{1'b0}}, fbp_q, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sysb_q  <= '0;
      rows_q  <= '0;
      width_q <= '0;
      fbb_q   <= '0;
      fbp_q   <= '0;
      sysp_q  <= '0;
      fillv_q <= '0;
    end else if (cfg_we && !busy) begin
      case (cfg_sel)
        3'd0: sysb_q  <= cfg_wdata;
        3'd1: rows_q  <= cfg_wdata[ROW_W-1:0];
        3'd2: width_q <= cfg_wdata[LEN_W-1:0];
        3'd3: fbb_q   <= cfg_wdata[FB_AW-1:3];
        3'd4: fbp_q   <= cfg_wdata[FBP_W-1:0];
        3'd5: sysp_q  <= cfg_wdata[SPT_W-1:0];
        3'd6: fillv_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      3'd0: cfg_rdata = sysb_q;
      3'd1: cfg_rdata[ROW_W-1:0] = rows_q;
      3'd2: cfg_rdata[LEN_W-1:0] = width_q;
      3'd3: cfg_rdata[FB_AW-1:3] = fbb_q;
      3'd4: cfg_rdata[FBP_W-1:0] = fbp_q;
      3'd5: cfg_rdata[SPT_W-1:0] = sysp_q;
      3'd6: cfg_rdata = fillv_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sys_ptr <= '0;
      fb_ptr  <= '0;
      left_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      done <= (go & empty) | (fire & req_last);
      if (go && !empty) begin
        busy    <= 1'b1;
        sys_ptr <= sysb_q;
        fb_ptr  <= {fbb_q, 3'b000};
        left_q  <= rows_q;
        mode_q  <= fill_en;
      end else if (fire) begin
        if (req_last) begin
          busy <= 1'b0;
        end else begin
          sys_ptr <= sys_ptr + {{(32-SPT_W){1'b0}}, sysp_q};
          fb_ptr  <= fb_ptr + fb_step;
          left_q  <= left_q - 1'b1;
        end
      end
    end
  end

  assign req_valid     = busy;
  assign req_sys_addr  = sys_ptr;
  assign req_fb_addr   = fb_ptr;
  assign req_len       = width_q;
  assign req_last      = (left_q == 1);
  assign req_fill      = mode_q;
  assign req_fill_data = mode_q ? fillv_q : 32'd0;
endmodule

// File: rtl/rect_xfer_agen_chk.sv
module rect_xfer_agen_chk #(
  parameter int FB_AW = 20,
  parameter int FBP_W = 10,
  parameter int SPT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cfg_we,
  input logic [31:0]      cfg_rdata,
  input logic [2:0]       cfg_sel,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_last,
  input logic [31:0]      req_sys_addr,
  input logic [FB_AW-1:0] req_fb_addr,
  input logic [11:0]      req_len,
  input logic [FBP_W-1:0] fbp_q,
  input logic [SPT_W-1:0] sysp_q,
  input logic             empty
);
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_sys_addr) && $stable(req_fb_addr) && $stable(req_len)); // R4

  AST_SYS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_last |=> req_sys_addr == $past(req_sys_addr) + 32'($past(sysp_q))); // R5

  AST_FB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_last |=> req_fb_addr == $past(req_fb_addr) + (FB_AW'($past(fbp_q)) << 3)); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_last |=> done && !busy); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && empty |=> done && !req_valid); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we |=> $stable(sysp_q) && $stable(fbp_q)); // R11
endmodule

bind rect_xfer_agen rect_xfer_agen_chk #(.FB_AW(FB_AW), .FBP_W(FBP_W), .SPT_W(SPT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .cfg_sel(cfg_sel),
  .req_valid(req_valid), .req_ready(req_ready), .req_last(req_last),
  .req_sys_addr(req_sys_addr), .req_fb_addr(req_fb_addr), .req_len(req_len),
  .fbp_q(fbp_q), .sysp_q(sysp_q), .empty(empty)
);

// File: tb/rect_xfer_agen_tb_top.sv
module rect_xfer_agen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        start = 1'b0;
  logic        fill_en = 1'b0;
  logic        busy, done, req_valid, req_last, req_fill;
  logic        req_ready = 1'b0;
  logic [31:0] req_sys_addr, req_fill_data;
  logic [19:0] req_fb_addr;
  logic [11:0] req_len;

  always #2 clk = ~clk;

  rect_xfer_agen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start),
    .fill_en(fill_en), .busy(busy), .done(done), .req_valid(req_valid),
    .req_ready(req_ready), .req_sys_addr(req_sys_addr),
    .req_fb_addr(req_fb_addr), .req_len(req_len), .req_last(req_last),
    .req_fill(req_fill), .req_fill_data(req_fill_data)
  );

  typedef struct {
    logic [31:0] sa;
    logic [19:0] fa;
    logic [11:0] ln;
    logic        fl;
    logic [31:0] fd;
    logic        lst;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  int ready_mode = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (ready_mode)
      1: req_ready <= 1'b1;
      2: req_ready <= 1'b0;
      default: req_ready <= $urandom_range(0, 1) == 1;
    endcase
  end

  logic        prev_stall = 1'b0;
  logic [31:0] prev_sa;
  logic [19:0] prev_fa;
  logic [11:0] prev_ln;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk("R4 valid held", {63'd0, req_valid}, 64'd1);
        chk("R4 sys addr held", {32'd0, req_sys_addr}, {32'd0, prev_sa});
        chk("R4 fb addr held", {44'd0, req_fb_addr}, {44'd0, prev_fa});
        chk("R4 len held", {52'd0, req_len}, {52'd0, prev_ln});
      end
      prev_stall = req_valid && !req_ready;
      prev_sa = req_sys_addr;
      prev_fa = req_fb_addr;
      prev_ln = req_len;
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected request", 64'd1, 64'd0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk("R5 sys addr", {32'd0, req_sys_addr}, {32'd0, e.sa});
          chk("R6 fb addr", {44'd0, req_fb_addr}, {44'd0, e.fa});
          chk("R3 len", {52'd0, req_len}, {52'd0, e.ln});
          chk("R10 fill flag", {63'd0, req_fill}, {63'd0, e.fl});
          chk("R10 fill data", {32'd0, req_fill_data}, {32'd0, e.fd});
          chk("R7 last flag", {63'd0, req_last}, {63'd0, e.lst});
        end
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(string req, input logic [2:0] sel, input logic [31:0] exp);
    cfg_sel = sel;
    #1;
    chk(req, {32'd0, cfg_rdata}, {32'd0, exp});
  endtask

  task automatic run_xfer(input logic [31:0] sb, input int rows, input int width,
                          input logic [19:0] fbb, input int fbp, input int sysp,
                          input bit fill, input logic [31:0] fv, input bit poke);
    logic [19:0] fb_al;
    int n;
    fb_al = fbb & 20'hFFFF8;
    wr(3'd0, sb); wr(3'd1, rows); wr(3'd2, width); wr(3'd3, {12'd0, fbb});
    wr(3'd4, fbp); wr(3'd5, sysp); wr(3'd6, fv);
    if (rows != 0 && width != 0)
      for (int i = 0; i < rows; i++) begin
        item_t e;
        e.sa = sb + 32'(i) * 32'(sysp);
        e.fa = 20'(fb_al + 32'(i) * 32'(fbp) * 8);
        e.ln = 12'(width);
        e.fl = fill;
        e.fd = fill ? fv : 32'd0;
        e.lst = (i == rows - 1);
        exp_q.push_back(e);
      end
    @(posedge clk); #1;
    start = 1'b1; fill_en = fill;
    @(posedge clk); #1;
    start = 1'b0; fill_en = 1'b0;
    if (rows == 0 || width == 0) begin
      @(negedge clk);
      chk("R9 done after empty start", {63'd0, done}, 64'd1);
      chk("R9 no request", {63'd0, req_valid}, 64'd0);
      chk("R9 busy low", {63'd0, busy}, 64'd0);
      @(negedge clk);
      chk("R9 done one cycle", {63'd0, done}, 64'd0);
      return;
    end
    @(negedge clk);
    chk("R3 busy after start", {63'd0, busy}, 64'd1);
    if (poke) begin
      wr(3'd5, 32'h777);
      @(posedge clk); #1; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
      ready_mode = 0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R8 done seen", {63'd0, done}, 64'd1);
    chk("R8 busy low at done", {63'd0, busy}, 64'd0);
    chk("R7 all rows issued", 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    chk("R8 done one cycle", {63'd0, done}, 64'd0);
    if (poke) rd("R11 write during busy ignored", 3'd5, 32'(sysp));
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 valid", {63'd0, req_valid}, 64'd0);
    for (int s = 0; s < 7; s++) rd("R1 reg zero", 3'(s), 32'd0);

    wr(3'd3, 32'hFFFFFFFF); rd("R2 fb base reserved", 3'd3, 32'h000FFFF8);
    wr(3'd1, 32'hFFFFFFFF); rd("R2 rows reserved", 3'd1, 32'h000003FF);
    wr(3'd2, 32'hFFFFFFFF); rd("R2 width reserved", 3'd2, 32'h00000FFF);
    wr(3'd4, 32'hFFFFFFFF); rd("R2 fb pitch reserved", 3'd4, 32'h000003FF);
    wr(3'd5, 32'hFFFFFFFF); rd("R2 sys pitch reserved", 3'd5, 32'h00000FFF);
    wr(3'd6, 32'hA5A5F00F); rd("R2 fill word", 3'd6, 32'hA5A5F00F);

    ready_mode = 0;
    run_xfer(32'h0000_1000, 4, 64, 20'h00100, 'h50, 'h800, 0, 32'h0, 0);
    run_xfer(32'h0020_0000, 3, 128, 20'h01238, 'h10, 'h200, 1, 32'hDEADBEEF, 0);
    ready_mode = 1;
    run_xfer(32'hFFFF_F000, 5, 4095, 20'hFFF00, 'h3FF, 'hFFF, 0, 32'h0, 0);
    run_xfer(32'h0000_0040, 1, 8, 20'h00010, 'h4, 'h40, 1, 32'h12345678, 0);
    run_xfer(32'h0000_0040, 0, 8, 20'h00010, 'h4, 'h40, 0, 32'h0, 0);
    run_xfer(32'h0000_0040, 6, 0, 20'h00010, 'h4, 'h40, 0, 32'h0, 0);
    ready_mode = 2;
    run_xfer(32'h0000_8000, 3, 32, 20'h00400, 'h20, 'h100, 0, 32'h0, 1);
    ready_mode = 0;
    run_xfer(32'h1000_0000, 1023, 16, 20'h00008, 'h2, 'h30, 0, 32'h0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule